// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block is a small memory-mapped register bank for chip-level control. Software reaches it through a plain synchronous bus: an address, a write strobe, write data, a registered read-data return and a one-cycle write-error flag. Writes that change state are gated twice. First, the whole bank stays write-protected until two 32-bit kick keys land, in order, at two kick registers. Second, the main device-control register also needs its own key, written to a companion lock register.

The bank holds device-control registers split into per-device fields, each with its own enable code. It turns those fields into a registered vector of per-device enable lines. Some devices can be switched on but never switched off again. Read-only status registers show a 3-bit field per device that follows the control state one cycle later. A read-only word carries a 4-bit silicon revision. A write-once register keeps its first accepted value until reset.

Top module: `keyed_cfg_bank`

## Requirements
- R1: Reset leaves the bank write-protected, the control lock closed, every control field, status field and enable line at 0, the write-once register empty, `bus_werr` low and `bus_rdata` zero.
- R2: The bank opens only after 0x83E70B13 is written to kick register A (byte offset 0x38) and then 0x95A4F1E0 to kick register B (0x3C). Before that, any write to a protected register (0x40004, 0x40008, 0x4002C, 0x40030) is dropped.
- R3: Writing a wrong value to kick B while A has been accepted, or writing kick B before A, leaves the bank closed. A wrong kick-B value also cancels a pending kick-A, so the sequence must restart from kick A.
- R4: Any value other than the kick-A key written to kick A closes an open bank again.
- R5: The control register at 0x40008 takes writes only while the bank is open and the lock register at 0x40004 has last received 0x0F0A0B00. Any other value written to 0x40004 closes that lock. Bit 0 of a read of 0x40004 shows 1 when the lock is open.
- R6: At 0x40008, devices 0 to 11 each own the 2-bit field at bits [2i+1:2i], and code 1 enables them. Device 12 owns bits [31:30], and code 3 enables it. Bits [29:24] read as 0. Enable line i is high exactly when device i's field holds its enable code.
- R7: At 0x4002C, devices 13 and 14 own bits 0 and 1, and code 1 enables them. Once a bit is 1, a write cannot clear it before reset.
- R8: Devices 0 to 9 report status in 3-bit fields at 0x40014, and devices 10 and 11 at 0x40018. Device k uses bits [3j+2:3j], where j is k or k-10. The field reads 1 when the device is enabled and 0 when it is disabled. A status field and the enable line both change on the second clock edge after the control write is sampled.
- R9: The word at 0x8 reads the silicon revision in bits [31:28] and 0 elsewhere. Writes to it, and to the status registers, change nothing.
- R10: The first write accepted at 0x40030 while the bank is open is stored. Later writes are ignored until reset.
- R11: `bus_werr` goes high for exactly the cycle after each dropped protected write (a closed bank, or a closed control lock at 0x40008). Accepted writes and kick writes never raise it.
- R12: Reads are allowed in any lock state. `bus_rdata` returns the addressed word one cycle after the address is sampled. Kick registers and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 20 | Byte address of the access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address sampled on the previous edge |
| bus_werr | output | 1 | One-cycle pulse after a dropped protected write |
| dev_en_o | output | 15 | Registered per-device enable lines, bit i for device i |

## Verification
The assertions assume the bus is used without overlap: one access per cycle, with the address and write data held steady around the sampling edge, and with reset held for at least one edge before its first release. They also assume nothing other than the bus changes the bank. The directed bench drives every access at the falling edge and leaves the strobe low between writes. It checks each result only after all registers on the path have updated, so every read or write is the only event in its cycle. Reset is applied mid-run to confirm that the write-once register and the sticky enable bits start fresh.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 20;
  localparam int SREV_W = 4;

  // Register offsets (bytes)
  localparam logic [ADDR_W-1:0] OFF_SILREV = 20'h00008;
  localparam logic [ADDR_W-1:0] OFF_KICKA  = 20'h00038;
  localparam logic [ADDR_W-1:0] OFF_KICKB  = 20'h0003C;
  localparam logic [ADDR_W-1:0] OFF_LOCK   = 20'h40004;
  localparam logic [ADDR_W-1:0] OFF_CTL    = 20'h40008;
  localparam logic [ADDR_W-1:0] OFF_STAT0  = 20'h40014;
  localparam logic [ADDR_W-1:0] OFF_STAT1  = 20'h40018;
  localparam logic [ADDR_W-1:0] OFF_CTL2   = 20'h4002C;
  localparam logic [ADDR_W-1:0] OFF_WONCE  = 20'h40030;

  localparam logic [DATA_W-1:0] KICKA_KEY_DEF = 32'h83E7_0B13;
  localparam logic [DATA_W-1:0] KICKB_KEY_DEF = 32'h95A4_F1E0;
  localparam logic [DATA_W-1:0] CTL_KEY_DEF   = 32'h0F0A_0B00;

  // Field group A: low devices in the main control word
  localparam int GA_N    = 12;
  localparam int GA_BITS = 2;
  localparam int GA_LSB  = 0;
  localparam int GA_EN   = 1;
  localparam int GA_DIS  = 0;
  // Field group B: top field of the main control word
  localparam int GB_N    = 1;
  localparam int GB_BITS = 2;
  localparam int GB_LSB  = 30;
  localparam int GB_EN   = 3;
  localparam int GB_DIS  = 0;
  // Field group C: enable-only devices in the second control word
  localparam int GC_N    = 2;
  localparam int GC_BITS = 1;
  localparam int GC_LSB  = 0;
  localparam int GC_EN   = 1;
  localparam int GC_DIS  = 0;

  localparam int NDEV = GA_N + GB_N + GC_N;

  // Status layout
  localparam int ST_BITS    = 3;
  localparam int ST_PER_REG = 10;
  localparam int ST_NREG    = 2;
  localparam int ST_EN      = 1;
  localparam int ST_DIS     = 0;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } kick_state_e;

endpackage

// File: rtl/kick_unlock.sv
module kick_unlock
  import keyed_cfg_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY_A = KICKA_KEY_DEF,
  parameter logic [DATA_W-1:0] KEY_B = KICKB_KEY_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_a_i,
  input  logic              wr_b_i,
  input  logic [DATA_W-1:0] wdata_i,
  output kick_state_e       state_o
);

  kick_state_e st_q;
  kick_state_e st_d;
  logic        key_a_ok;
  logic        key_b_ok;

  assign key_a_ok = (wdata_i == KEY_A);
  assign key_b_ok = (wdata_i == KEY_B);

  always_comb begin
    st_d = st_q;
    if (wr_a_i) begin
      if (!key_a_ok)
        st_d = KS_LOCKED;
      else if (st_q != KS_OPEN)
        st_d = KS_HALF;
    end else if (wr_b_i) begin
      if (st_q == KS_HALF)
        st_d = key_b_ok ? KS_OPEN : KS_LOCKED;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= KS_LOCKED;
    else     st_q <= st_d;
  end

  assign state_o = st_q;

endmodule

// File: rtl/dev_field_bank.sv
module dev_field_bank
  import keyed_cfg_pkg::*;
#(
  parameter int NDEVS   = 12,
  parameter int FBITS   = 2,
  parameter int LSB     = 0,
  parameter int EN_CODE = 1,
  parameter int RST_CODE = 0,
  parameter bit CAN_DIS = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] img_o,
  output logic [NDEVS-1:0]  en_o
);

  localparam logic [FBITS-1:0] EN_F  = FBITS'(EN_CODE);
  localparam logic [FBITS-1:0] RST_F = FBITS'(RST_CODE);

  logic [DATA_W-1:0] part [NDEVS];
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;

  for (genvar g = 0; g < NDEVS; g++) begin : g_dev
    localparam int FLO = LSB + g * FBITS;
    logic [FBITS-1:0] fld_q;
    logic [FBITS-1:0] fld_wr;

    assign fld_wr = wdata_i[FLO +: FBITS];

    if (CAN_DIS) begin : g_free
      always_ff @(posedge clk) begin
        if (rst)       fld_q <= RST_F;
        else if (wr_i) fld_q <= fld_wr;
      end
    end else begin : g_sticky
      always_ff @(posedge clk) begin
        if (rst)                        fld_q <= RST_F;
        else if (wr_i && fld_q != EN_F) fld_q <= fld_wr;
      end
    end

    assign en_o[g] = (fld_q == EN_F);
    assign part[g] = DATA_W'(fld_q) << FLO;
  end

  always_comb begin
    img_o = '0;
    for (int i = 0; i < NDEVS; i++) img_o = img_o | part[i];
  end

endmodule

// File: rtl/status_mirror.sv
module status_mirror
  import keyed_cfg_pkg::*;
#(
  parameter int NDEVS   = 12,
  parameter int PER_REG = ST_PER_REG,
  parameter int NREG    = ST_NREG,
  parameter int SBITS   = ST_BITS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NDEVS-1:0]       en_i,
  output logic [NDEVS-1:0]       st_o,
  output logic [NREG*DATA_W-1:0] img_o
);

  localparam int IMG_W = NREG * DATA_W;
  localparam logic [SBITS-1:0] CODE_ON  = SBITS'(ST_EN);
  localparam logic [SBITS-1:0] CODE_OFF = SBITS'(ST_DIS);

  logic [NDEVS-1:0] st_q;
  logic [IMG_W-1:0] part [NDEVS];

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= en_i;
  end

  for (genvar d = 0; d < NDEVS; d++) begin : g_st
    localparam int RIDX = d / PER_REG;
    localparam int SIDX = d % PER_REG;
    localparam int POS  = RIDX * DATA_W + SIDX * SBITS;
    assign part[d] = IMG_W'(st_q[d] ? CODE_ON : CODE_OFF) << POS;
  end

  always_comb begin
    img_o = '0;
    for (int i = 0; i < NDEVS; i++) img_o = img_o | part[i];
  end

  assign st_o = st_q;

endmodule

// File: rtl/keyed_cfg_bank.sv
module keyed_cfg_bank
  import keyed_cfg_pkg::*;
#(
  parameter logic [DATA_W-1:0] KICK_KEY_A = KICKA_KEY_DEF,
  parameter logic [DATA_W-1:0] KICK_KEY_B = KICKB_KEY_DEF,
  parameter logic [DATA_W-1:0] CTL_KEY    = CTL_KEY_DEF,
  parameter logic [SREV_W-1:0] SIL_REV    = 4'h3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_werr,
  output logic [NDEV-1:0]   dev_en_o
);

  localparam int ST_DEVS = GA_N;

  kick_state_e kick_st;
  logic        bank_open;
  logic        hit_ka, hit_kb, hit_lock, hit_ctl, hit_ctl2, hit_wo, hit_prot;
  logic        wr_lock, wr_ctl, wr_ctl2, wr_wo;
  logic        werr_d;
  logic        ctl_unl_q;
  logic [DATA_W-1:0] wo_val_q;
  logic        wo_done_q;
  logic [DATA_W-1:0] img_a, img_b, img_c;
  logic [GA_N-1:0]   en_a;
  logic [GB_N-1:0]   en_b;
  logic [GC_N-1:0]   en_c;
  logic [ST_DEVS-1:0] stat_en;
  logic [ST_NREG*DATA_W-1:0] stat_img;
  logic [DATA_W-1:0] rd_d;

  // Address decode
  assign hit_ka   = (bus_addr == OFF_KICKA);
  assign hit_kb   = (bus_addr == OFF_KICKB);
  assign hit_lock = (bus_addr == OFF_LOCK);
  assign hit_ctl  = (bus_addr == OFF_CTL);
  assign hit_ctl2 = (bus_addr == OFF_CTL2);
  assign hit_wo   = (bus_addr == OFF_WONCE);
  assign hit_prot = hit_lock | hit_ctl | hit_ctl2 | hit_wo;

  kick_unlock #(
    .KEY_A (KICK_KEY_A),
    .KEY_B (KICK_KEY_B)
  ) u_kick (
    .clk     (clk),
    .rst     (rst),
    .wr_a_i  (bus_we & hit_ka),
    .wr_b_i  (bus_we & hit_kb),
    .wdata_i (bus_wdata),
    .state_o (kick_st)
  );

  assign bank_open = (kick_st == KS_OPEN);

  // Write gating
  assign wr_lock = bus_we & hit_lock & bank_open;
  assign wr_ctl  = bus_we & hit_ctl  & bank_open & ctl_unl_q;
  assign wr_ctl2 = bus_we & hit_ctl2 & bank_open;
  assign wr_wo   = bus_we & hit_wo   & bank_open;
  assign werr_d  = bus_we & ((hit_prot & ~bank_open) | (hit_ctl & ~ctl_unl_q));

  // Per-register lock for the main control word
  always_ff @(posedge clk) begin
    if (rst)          ctl_unl_q <= 1'b0;
    else if (wr_lock) ctl_unl_q <= (bus_wdata == CTL_KEY);
  end

  // Write-once word
  always_ff @(posedge clk) begin
    if (rst) begin
      wo_val_q  <= '0;
      wo_done_q <= 1'b0;
    end else if (wr_wo && !wo_done_q) begin
      wo_val_q  <= bus_wdata;
      wo_done_q <= 1'b1;
    end
  end

  dev_field_bank #(
    .NDEVS (GA_N), .FBITS (GA_BITS), .LSB (GA_LSB),
    .EN_CODE (GA_EN), .RST_CODE (GA_DIS), .CAN_DIS (1'b1)
  ) u_grp_a (
    .clk (clk), .rst (rst), .wr_i (wr_ctl), .wdata_i (bus_wdata),
    .img_o (img_a), .en_o (en_a)
  );

  dev_field_bank #(
    .NDEVS (GB_N), .FBITS (GB_BITS), .LSB (GB_LSB),
    .EN_CODE (GB_EN), .RST_CODE (GB_DIS), .CAN_DIS (1'b1)
  ) u_grp_b (
    .clk (clk), .rst (rst), .wr_i (wr_ctl), .wdata_i (bus_wdata),
    .img_o (img_b), .en_o (en_b)
  );

  dev_field_bank #(
    .NDEVS (GC_N), .FBITS (GC_BITS), .LSB (GC_LSB),
    .EN_CODE (GC_EN), .RST_CODE (GC_DIS), .CAN_DIS (1'b0)
  ) u_grp_c (
    .clk (clk), .rst (rst), .wr_i (wr_ctl2), .wdata_i (bus_wdata),
    .img_o (img_c), .en_o (en_c)
  );

  status_mirror #(
    .NDEVS (ST_DEVS)
  ) u_stat (
    .clk   (clk),
    .rst   (rst),
    .en_i  (en_a),
    .st_o  (stat_en),
    .img_o (stat_img)
  );

  // Read mux
  always_comb begin
    rd_d = '0;
    case (bus_addr)
      OFF_SILREV: rd_d[DATA_W-1 -: SREV_W] = SIL_REV;
      OFF_LOCK:   rd_d[0] = ctl_unl_q;
      OFF_CTL:    rd_d = img_a | img_b;
      OFF_CTL2:   rd_d = img_c;
      OFF_STAT0:  rd_d = stat_img[DATA_W-1:0];
      OFF_STAT1:  rd_d = stat_img[2*DATA_W-1:DATA_W];
      OFF_WONCE:  rd_d = wo_val_q;
      default:    rd_d = '0;
    endcase
  end

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_werr  <= 1'b0;
      dev_en_o  <= '0;
    end else begin
      bus_rdata <= rd_d;
      bus_werr  <= werr_d;
      dev_en_o  <= {en_c, en_b, en_a};
    end
  end

endmodule

// File: rtl/keyed_cfg_bank_chk.sv
module keyed_cfg_bank_chk
  import keyed_cfg_pkg::*;
#(
  parameter logic [SREV_W-1:0] SIL_REV = 4'h3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_werr,
  input logic [NDEV-1:0]   dev_en_o,
  input kick_state_e       kick_st,
  input logic              ctl_unl,
  input logic [GA_N-1:0]   stat_en,
  input logic              wo_done,
  input logic [DATA_W-1:0] wo_val
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (dev_en_o == '0) && !bus_werr && (bus_rdata == '0));

  // R3
  open_via_half_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
    (kick_st == KS_OPEN && $past(kick_st) != KS_OPEN) |-> ($past(kick_st) == KS_HALF));

  // R5
  ctl_needs_key_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
    (dev_en_o[GA_N+GB_N-1:0] != $past(dev_en_o[GA_N+GB_N-1:0])) |-> $past(ctl_unl, 2));

  // R7
  sticky_en_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
    !$fell(dev_en_o[NDEV-1]) && !$fell(dev_en_o[NDEV-2]));

  // R8
  status_track_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
    stat_en == dev_en_o[GA_N-1:0]);

  // R9
  silrev_read_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
    ($past(bus_addr) == OFF_SILREV) |-> (bus_rdata == {SIL_REV, {(DATA_W-SREV_W){1'b0}}}));

  // R10
  write_once_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
    $past(wo_done) |-> $stable(wo_val));

  // R11
  werr_cause_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
    bus_werr |-> $past(bus_we));

endmodule

bind keyed_cfg_bank keyed_cfg_bank_chk #(.SIL_REV(SIL_REV)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .bus_werr  (bus_werr),
  .dev_en_o  (dev_en_o),
  .kick_st   (kick_st),
  .ctl_unl   (ctl_unl_q),
  .stat_en   (stat_en),
  .wo_done   (wo_done_q),
  .wo_val    (wo_val_q)
);

// File: tb/keyed_cfg_bank_bench.sv
module keyed_cfg_bank_bench;

  localparam logic [31:0] KA  = 32'h83E7_0B13;
  localparam logic [31:0] KB  = 32'h95A4_F1E0;
  localparam logic [31:0] LK  = 32'h0F0A_0B00;
  localparam logic [19:0] A_SREV = 20'h00008, A_KA = 20'h00038, A_KB = 20'h0003C;
  localparam logic [19:0] A_LOCK = 20'h40004, A_CTL = 20'h40008, A_ST0 = 20'h40014;
  localparam logic [19:0] A_ST1 = 20'h40018, A_CTL2 = 20'h4002C, A_WO = 20'h40030;

  logic        clk = 1'b0;
  logic        rst;
  logic [19:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_werr;
  logic [14:0] dev_en_o;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #5 clk = ~clk;

  keyed_cfg_bank u_keyed_cfg_bank (
    .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_we (bus_we),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .bus_werr (bus_werr),
    .dev_en_o (dev_en_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [19:0] a, input logic [31:0] d, output logic err);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
    err = bus_werr;
  endtask

  task automatic bus_rd(input logic [19:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic open_bank();
    logic e;
    bus_wr(A_KA, KA, e);
    bus_wr(A_KB, KB, e);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 dev_en after reset", 32'(dev_en_o), 32'h0);
    chk("R1 werr after reset", 32'(bus_werr), 32'h0);
    bus_rd(A_CTL, d);  chk("R1 ctl after reset", d, 32'h0);
    bus_rd(A_LOCK, d); chk("R1 lock closed after reset", d, 32'h0);
    bus_rd(A_WO, d);   chk("R1 write-once empty after reset", d, 32'h0);
  endtask

  task automatic t_locked();
    logic e; logic [31:0] d;
    bus_wr(A_CTL2, 32'h3, e); chk("R2 locked write flagged", 32'(e), 32'h1);
    idle();                   chk("R11 werr single cycle", 32'(bus_werr), 32'h0);
    bus_rd(A_CTL2, d);        chk("R2 locked write dropped", d, 32'h0);
    bus_rd(A_KA, d);          chk("R12 kick reads zero", d, 32'h0);
  endtask

  task automatic t_order();
    logic e; logic [31:0] d;
    bus_wr(A_KB, KB, e);      chk("R11 kick write no werr", 32'(e), 32'h0);
    bus_wr(A_KA, KA, e);
    bus_wr(A_CTL2, 32'h1, e); chk("R3 kick B before A stays closed", 32'(e), 32'h1);
    bus_wr(A_KB, 32'h1234_5678, e); chk("R11 wrong kick no werr", 32'(e), 32'h0);
    bus_wr(A_KB, KB, e);
    bus_wr(A_CTL2, 32'h1, e); chk("R3 wrong kick B cancels", 32'(e), 32'h1);
    bus_rd(A_CTL2, d);        chk("R3 still nothing written", d, 32'h0);
  endtask

  task automatic t_open();
    logic e; logic [31:0] d;
    open_bank();
    bus_wr(A_CTL2, 32'h1, e); chk("R2 open bank accepts write", 32'(e), 32'h0);
    idle();                   chk("R7 dev13 enabled", 32'(dev_en_o[14:13]), 32'h1);
    bus_rd(A_CTL2, d);        chk("R7 ctl2 readback", d, 32'h1);
  endtask

  task automatic t_sticky();
    logic e; logic [31:0] d;
    bus_wr(A_CTL2, 32'h0, e);
    bus_rd(A_CTL2, d);        chk("R7 clear ignored", d, 32'h1);
    bus_wr(A_CTL2, 32'h2, e);
    bus_rd(A_CTL2, d);        chk("R7 second bit set, first kept", d, 32'h3);
    chk("R7 both sticky enables", 32'(dev_en_o[14:13]), 32'h3);
  endtask

  task automatic t_lock_ctl();
    logic e; logic [31:0] d;
    bus_wr(A_CTL, 32'h1, e);  chk("R5 ctl write without key flagged", 32'(e), 32'h1);
    bus_rd(A_CTL, d);         chk("R5 ctl unchanged without key", d, 32'h0);
    bus_wr(A_LOCK, 32'h1234_5678, e); chk("R11 wrong lock key no werr", 32'(e), 32'h0);
    bus_rd(A_LOCK, d);        chk("R5 wrong key keeps lock closed", d, 32'h0);
    bus_wr(A_LOCK, LK, e);
    bus_rd(A_LOCK, d);        chk("R5 lock open after key", d, 32'h1);
    bus_wr(A_CTL, 32'hFF00_04E1, e); chk("R5 ctl write accepted", 32'(e), 32'h0);
    bus_rd(A_CTL, d);         chk("R6 field layout readback", d, 32'hC000_04E1);
    chk("R6 enable decode", 32'(dev_en_o), 32'h0000_7021);
    bus_wr(A_LOCK, 32'h0, e);
    bus_wr(A_CTL, 32'h0, e);  chk("R5 relocked write flagged", 32'(e), 32'h1);
    bus_rd(A_CTL, d);         chk("R5 relocked ctl kept", d, 32'hC000_04E1);
  endtask

  task automatic t_status();
    logic e; logic [31:0] d;
    bus_rd(A_ST0, d);         chk("R8 status low group", d, 32'h0000_8001);
    bus_rd(A_ST1, d);         chk("R8 status high group idle", d, 32'h0);
    bus_wr(A_LOCK, LK, e);
    bus_wr(A_CTL, 32'hC040_04E1, e);
    bus_rd(A_ST1, d);         chk("R8 status lags one cycle", d, 32'h0);
    bus_rd(A_ST1, d);         chk("R8 status follows control", d, 32'h0000_0008);
    chk("R8 dev11 enable line", 32'(dev_en_o[11]), 32'h1);
  endtask

  task automatic t_silrev();
    logic e; logic [31:0] d;
    bus_rd(A_SREV, d);        chk("R9 revision read", d, 32'h3000_0000);
    bus_wr(A_SREV, 32'hFFFF_FFFF, e); chk("R9 write to read-only no werr", 32'(e), 32'h0);
    bus_rd(A_SREV, d);        chk("R9 revision unchanged", d, 32'h3000_0000);
    bus_wr(A_ST0, 32'hFFFF_FFFF, e);
    bus_rd(A_ST0, d);         chk("R9 status write ignored", d, 32'h0000_8001);
  endtask

  task automatic t_wonce();
    logic e; logic [31:0] d;
    bus_wr(A_WO, 32'hA5A5_0F0F, e); chk("R10 first write accepted", 32'(e), 32'h0);
    bus_rd(A_WO, d);          chk("R10 first value stored", d, 32'hA5A5_0F0F);
    bus_wr(A_WO, 32'h0000_1234, e);
    bus_rd(A_WO, d);          chk("R10 second write ignored", d, 32'hA5A5_0F0F);
  endtask

  task automatic t_relock();
    logic e; logic [31:0] d;
    bus_wr(A_KA, 32'h0, e);   chk("R11 relock kick no werr", 32'(e), 32'h0);
    bus_wr(A_LOCK, LK, e);    chk("R4 bank closed after bad kick A", 32'(e), 32'h1);
    bus_rd(A_CTL, d);         chk("R12 read while closed", d, 32'hC040_04E1);
  endtask

  task automatic t_reset_again();
    logic e; logic [31:0] d;
    do_reset();
    chk("R1 enables cleared by reset", 32'(dev_en_o), 32'h0);
    bus_rd(A_WO, d);          chk("R1 write-once cleared", d, 32'h0);
    bus_rd(A_CTL2, d);        chk("R1 sticky bits cleared", d, 32'h0);
    bus_wr(A_WO, 32'h77, e);  chk("R2 closed again after reset", 32'(e), 32'h1);
    open_bank();
    bus_wr(A_WO, 32'h77, e);
    bus_rd(A_WO, d);          chk("R10 writable again after reset", d, 32'h77);
  endtask

  initial begin
    rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_locked();
    t_order();
    t_open();
    t_sticky();
    t_lock_ctl();
    t_status();
    t_silrev();
    t_wonce();
    t_relock();
    t_reset_again();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule